// File: doc/BRIEF.md
# Serial Port Status Flag and Interrupt Controller

This block keeps the sticky status flags of a serial port and folds them into a single interrupt request. The transmit and receive datapaths report events as one-cycle strobes. These events are a holding-register-to-shifter load, the end of a transmitted frame, a receive shifter-to-data-register transfer and a detected line break. The block also watches an asynchronous clear-to-send modem input. It synchronises that input and raises a flag whenever the line changes level while flow control is enabled.

A host reaches the block through a simple register port with read and write strobes, an address and write data. Each flag has its own clearing paths. Some are cleared by a write-one-to-clear register. Others are cleared as a side effect of a transmit data write or a receive data read. A request register provides transmit and receive flush commands. A per-flag enable register masks the flags onto the interrupt line. Break support can be removed at elaboration time, and that flag then reads as constant zero.

Flag bit positions, used in the status, enable and clear registers: bit 0 receive-ready, bit 1 transmit-empty, bit 2 transmit-done, bit 3 CTS-changed, bit 4 break. Addresses: 0 status (read-only), 1 interrupt enable, 2 clear (write one to clear), 3 request (bit 0 receive flush, bit 1 transmit flush), 4 transmit data write, 5 receive data read.

Top module: `uart_flag_ctrl`

## Requirements
- R1: After reset the flags read 0b00010 (only transmit-empty set), the enable register reads 0 and irq is low.
- R2: Transmit-empty (bit 1) sets the cycle after tx_load. It clears after a write to address 4 or a write of bit 1 to address 3.
- R3: Transmit-done (bit 2) sets after tx_frame_done only if transmit-empty is already 1 in that cycle. Otherwise it stays 0.
- R4: Transmit-done clears after a write with bit 2 set to address 2, or after any write to address 4.
- R5: While tx_en is low and tx_busy is low, transmit-done is set on every clock edge.
- R6: Receive-ready (bit 0) sets the cycle after rx_xfer. It clears after a read of address 5 or a write of bit 0 to address 3.
- R7: With cts_fc_en high, a level change on cts_async sets CTS-changed (bit 3) on the third clock edge after the change, when SYNC_STAGES is 2. With cts_fc_en low, a change leaves the flag clear. The flag clears after writing bit 3 to address 2.
- R8: Break (bit 4) sets after brk_det and clears after writing bit 4 to address 2. With HAS_BREAK = 0 it is always 0.
- R9: When a set event and a clear command hit the same flag in the same cycle, the flag ends up set.
- R10: irq equals the OR over all flags of each flag ANDed with its enable bit. The enable bits are written at address 1 and read back from address 1.
- R11: Writes to address 0 change no flag. Writing ones to address 2 in bits 0 and 1 changes no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_load | input | 1 | Holding register moved into the transmit shifter |
| tx_frame_done | input | 1 | A data frame finished shifting out |
| tx_en | input | 1 | Transmitter enable |
| tx_busy | input | 1 | Transmission in progress |
| rx_xfer | input | 1 | Received word moved into the receive data register |
| brk_det | input | 1 | Line break detected |
| cts_async | input | 1 | Asynchronous clear-to-send line |
| cts_fc_en | input | 1 | CTS flow control enable |
| rd_en | input | 1 | Host read strobe |
| wr_en | input | 1 | Host write strobe |
| addr | input | ADDR_W | Host register address |
| wdata | input | DATA_W | Host write data |
| rdata | output | DATA_W | Host read data (combinational, zero when rd_en is low) |
| flags_o | output | 5 | Current flag vector |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check several properties. Each set strobe must produce its flag on the next edge. Transmit-done must follow a qualified frame end and the idle-transmitter condition. The break flag must win over a simultaneous clear, or stay at zero when break support is absent. The interrupt must always match the masked OR of the flags, and receive-ready must never rise without a transfer strobe. Other behaviours can only be shown by the bench's scenarios: the clearing paths through data accesses, flushes and the clear register, the exact synchroniser delay on the CTS input and its suppression when flow control is off, the enable readback, and the fact that writes to the status address or to non-clearable clear bits are ignored.

// File: rtl/uart_flag_pkg.sv
package uart_flag_pkg;
   localparam int NUM_FLAGS = 5;
   localparam int F_RXRDY   = 0;
   localparam int F_TXEMP   = 1;
   localparam int F_TXDONE  = 2;
   localparam int F_CTSCHG  = 3;
   localparam int F_BREAK   = 4;

   localparam int REQ_RXFLUSH = 0;
   localparam int REQ_TXFLUSH = 1;

   typedef enum logic [2:0] {
      A_STATUS  = 3'd0,
      A_IRQEN   = 3'd1,
      A_CLEAR   = 3'd2,
      A_REQUEST = 3'd3,
      A_TXDATA  = 3'd4,
      A_RXDATA  = 3'd5
   } reg_addr_e;

   typedef struct packed {
      logic clr_txdone;
      logic clr_cts;
      logic clr_brk;
      logic tx_wr;
      logic rx_rd;
      logic rx_flush;
      logic tx_flush;
   } host_evt_t;
endpackage

// File: rtl/uart_flag_cts_sync.sv
module uart_flag_cts_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cts_async,
   input  logic fc_en,
   output logic toggle_o
);
   logic [STAGES-1:0] sync_q;
   logic              prev_q;
   logic              synced;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= {STAGES{RST_LVL}};
         prev_q <= RST_LVL;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], cts_async};
         prev_q <= synced;
      end
   end

   assign synced   = sync_q[STAGES-1];
   assign toggle_o = fc_en && (synced ^ prev_q);
endmodule

// File: rtl/uart_flag_host.sv
module uart_flag_host
   import uart_flag_pkg::*;
#(
   parameter int ADDR_W = 3,
   parameter int DATA_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 rd_en,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   input  logic [NUM_FLAGS-1:0] flags_i,
   output host_evt_t            evt_o,
   output logic [NUM_FLAGS-1:0] irq_en_o,
   output logic [DATA_W-1:0]    rdata
);
   localparam int PAD_W = DATA_W - NUM_FLAGS;

   logic wr_clear, wr_req, wr_en_reg, wr_txd, rd_rxd;
   logic [NUM_FLAGS-1:0] en_q;
   logic unused_wdata;

   assign wr_clear  = wr_en && (addr == ADDR_W'(A_CLEAR));
   assign wr_req    = wr_en && (addr == ADDR_W'(A_REQUEST));
   assign wr_en_reg = wr_en && (addr == ADDR_W'(A_IRQEN));
   assign wr_txd    = wr_en && (addr == ADDR_W'(A_TXDATA));
   assign rd_rxd    = rd_en && (addr == ADDR_W'(A_RXDATA));
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         en_q <= '0;
      else if (wr_en_reg) en_q <= wdata[NUM_FLAGS-1:0];
   end

   always_comb begin
      evt_o            = '0;
      evt_o.clr_txdone = wr_clear && wdata[F_TXDONE];
      evt_o.clr_cts    = wr_clear && wdata[F_CTSCHG];
      evt_o.clr_brk    = wr_clear && wdata[F_BREAK];
      evt_o.tx_wr      = wr_txd;
      evt_o.rx_rd      = rd_rxd;
      evt_o.rx_flush   = wr_req && wdata[REQ_RXFLUSH];
      evt_o.tx_flush   = wr_req && wdata[REQ_TXFLUSH];
   end

   generate
      if (PAD_W > 0) begin : g_pad
         always_comb begin
            rdata = '0;
            if (rd_en) begin
               if (addr == ADDR_W'(A_STATUS))     rdata = {{PAD_W{1'b0}}, flags_i};
               else if (addr == ADDR_W'(A_IRQEN)) rdata = {{PAD_W{1'b0}}, en_q};
            end
         end
      end else begin : g_nopad
         always_comb begin
            rdata = '0;
            if (rd_en) begin
               if (addr == ADDR_W'(A_STATUS))     rdata = flags_i;
               else if (addr == ADDR_W'(A_IRQEN)) rdata = en_q;
            end
         end
      end
   endgenerate

   assign irq_en_o = en_q;
endmodule

// File: rtl/uart_flag_bits.sv
module uart_flag_bits
   import uart_flag_pkg::*;
#(
   parameter bit HAS_BREAK = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tx_load,
   input  logic                 tx_frame_done,
   input  logic                 tx_en,
   input  logic                 tx_busy,
   input  logic                 rx_xfer,
   input  logic                 cts_toggle,
   input  logic                 brk_det,
   input  host_evt_t            evt,
   output logic [NUM_FLAGS-1:0] flags_o
);
   localparam logic [NUM_FLAGS-1:0] FLAG_RST = NUM_FLAGS'(1) << F_TXEMP;

   logic [NUM_FLAGS-1:0] set_vec, clr_vec;

   always_comb begin
      set_vec = '0;
      clr_vec = '0;
      set_vec[F_RXRDY]  = rx_xfer;
      clr_vec[F_RXRDY]  = evt.rx_rd || evt.rx_flush;
      set_vec[F_TXEMP]  = tx_load;
      clr_vec[F_TXEMP]  = evt.tx_wr || evt.tx_flush;
      set_vec[F_TXDONE] = (tx_frame_done && flags_o[F_TXEMP]) || (!tx_en && !tx_busy);
      clr_vec[F_TXDONE] = evt.tx_wr || evt.clr_txdone;
      set_vec[F_CTSCHG] = cts_toggle;
      clr_vec[F_CTSCHG] = evt.clr_cts;
      set_vec[F_BREAK]  = brk_det;
      clr_vec[F_BREAK]  = evt.clr_brk;
   end

   generate
      for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
         if (i == F_BREAK && !HAS_BREAK) begin : g_absent
            logic unused_brk;
            assign unused_brk = set_vec[i] ^ clr_vec[i];
            assign flags_o[i] = 1'b0;
         end else begin : g_store
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)          q <= FLAG_RST[i];
               else if (set_vec[i]) q <= 1'b1;
               else if (clr_vec[i]) q <= 1'b0;
            end
            assign flags_o[i] = q;
         end
      end
   endgenerate
endmodule

// File: rtl/uart_flag_ctrl.sv
module uart_flag_ctrl
   import uart_flag_pkg::*;
#(
   parameter int   ADDR_W      = 3,
   parameter int   DATA_W      = 8,
   parameter int   SYNC_STAGES = 2,
   parameter bit   HAS_BREAK   = 1'b1,
   parameter logic CTS_RST_LVL = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tx_load,
   input  logic                 tx_frame_done,
   input  logic                 tx_en,
   input  logic                 tx_busy,
   input  logic                 rx_xfer,
   input  logic                 brk_det,
   input  logic                 cts_async,
   input  logic                 cts_fc_en,
   input  logic                 rd_en,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   output logic [NUM_FLAGS-1:0] flags_o,
   output logic                 irq
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("uart_flag_ctrl: SYNC_STAGES must be at least 2");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("uart_flag_ctrl: ADDR_W must be at least 3");
      end
      if (DATA_W < NUM_FLAGS) begin : g_bad_data
         $error("uart_flag_ctrl: DATA_W must hold every flag");
      end
   endgenerate

   host_evt_t            evt;
   logic [NUM_FLAGS-1:0] irq_en;
   logic                 cts_toggle;

   uart_flag_cts_sync #(.STAGES(SYNC_STAGES), .RST_LVL(CTS_RST_LVL)) u_cts (
      .clk(clk), .rst_n(rst_n), .cts_async(cts_async), .fc_en(cts_fc_en),
      .toggle_o(cts_toggle)
   );

   uart_flag_host #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_host (
      .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
      .wdata(wdata), .flags_i(flags_o), .evt_o(evt), .irq_en_o(irq_en),
      .rdata(rdata)
   );

   uart_flag_bits #(.HAS_BREAK(HAS_BREAK)) u_bits (
      .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .tx_frame_done(tx_frame_done),
      .tx_en(tx_en), .tx_busy(tx_busy), .rx_xfer(rx_xfer), .cts_toggle(cts_toggle),
      .brk_det(brk_det), .evt(evt), .flags_o(flags_o)
   );

   assign irq = |(flags_o & irq_en);
endmodule

// File: rtl/uart_flag_chk.sv
module uart_flag_chk #(
   parameter bit HAS_BREAK = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       tx_load,
   input logic       tx_frame_done,
   input logic       tx_en,
   input logic       tx_busy,
   input logic       rx_xfer,
   input logic       brk_det,
   input logic [4:0] flags_o,
   input logic [4:0] irq_en,
   input logic       irq
);
   assert_rx_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_xfer |=> flags_o[0]);
   assert_rx_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_o[0]) |-> $past(rx_xfer));
   assert_txe_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tx_load |=> flags_o[1]);
   assert_done_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_frame_done && flags_o[1]) |=> flags_o[2]);
   assert_idle_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en && !tx_busy) |=> flags_o[2]);
   assert_irq_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq == |(flags_o & irq_en));

   generate
      if (HAS_BREAK) begin : g_brk
         assert_brk_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
            brk_det |=> flags_o[4]);
      end else begin : g_nobrk
         assert_brk_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !flags_o[4]);
      end
   endgenerate
endmodule

bind uart_flag_ctrl uart_flag_chk #(.HAS_BREAK(HAS_BREAK)) u_chk (
   .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .tx_frame_done(tx_frame_done),
   .tx_en(tx_en), .tx_busy(tx_busy), .rx_xfer(rx_xfer), .brk_det(brk_det),
   .flags_o(flags_o), .irq_en(irq_en), .irq(irq)
);

// File: tb/uart_flag_ctrl_test.sv
module uart_flag_ctrl_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tx_load = 0, tx_frame_done = 0, tx_en = 1, tx_busy = 1, rx_xfer = 0;
   logic brk_det = 0, cts_async = 1, cts_fc_en = 1, rd_en = 0, wr_en = 0;
   logic [2:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata, rdata_nb;
   logic [4:0] flags, flags_nb;
   logic irq, irq_nb;
   int tests = 0, fails = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   uart_flag_ctrl uut (
      .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .tx_frame_done(tx_frame_done),
      .tx_en(tx_en), .tx_busy(tx_busy), .rx_xfer(rx_xfer), .brk_det(brk_det),
      .cts_async(cts_async), .cts_fc_en(cts_fc_en), .rd_en(rd_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .flags_o(flags), .irq(irq));

   uart_flag_ctrl #(.HAS_BREAK(1'b0)) uut_nb (
      .clk(clk), .rst_n(rst_n), .tx_load(tx_load), .tx_frame_done(tx_frame_done),
      .tx_en(tx_en), .tx_busy(tx_busy), .rx_xfer(rx_xfer), .brk_det(brk_det),
      .cts_async(cts_async), .cts_fc_en(cts_fc_en), .rd_en(rd_en), .wr_en(wr_en),
      .addr(addr), .wdata(wdata), .rdata(rdata_nb), .flags_o(flags_nb), .irq(irq_nb));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // every task starts and ends at a falling edge
   task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
      wr_en = 1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 0; wdata = '0; addr = '0;
   endtask

   task automatic host_rd_rx();
      rd_en = 1; addr = 3'd5;
      @(negedge clk);
      rd_en = 0; addr = '0;
   endtask

   task automatic peek(input logic [2:0] a, output logic [7:0] v);
      rd_en = 1; addr = a;
      #1 v = rdata;
      rd_en = 0; addr = '0;
   endtask

   task automatic pulse_load();
      tx_load = 1; @(negedge clk); tx_load = 0;
   endtask
   task automatic pulse_frame();
      tx_frame_done = 1; @(negedge clk); tx_frame_done = 0;
   endtask
   task automatic pulse_rx();
      rx_xfer = 1; @(negedge clk); rx_xfer = 0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      chk("R1 flags", flags, 5'b00010);
      chk("R1 irq", irq, 0);
      peek(3'd1, v);
      chk("R1 enable", v, 0);
   endtask

   task automatic t_txe();
      host_wr(3'd4, 8'h00);
      chk("R2 txe cleared by data write", flags[1], 0);
      pulse_load();
      chk("R2 txe set by load", flags[1], 1);
      host_wr(3'd3, 8'h02);
      chk("R2 txe cleared by flush", flags[1], 0);
   endtask

   task automatic t_tc();
      pulse_frame();
      chk("R3 no done without txe", flags[2], 0);
      pulse_load();
      pulse_frame();
      chk("R3 done with txe", flags[2], 1);
      host_wr(3'd2, 8'h04);
      chk("R4 done W1C", flags[2], 0);
      pulse_frame();
      chk("R3 done again", flags[2], 1);
      host_wr(3'd4, 8'h00);
      chk("R4 done cleared by data write", flags[2], 0);
   endtask

   task automatic t_idle();
      tx_en = 0; tx_busy = 0;
      @(negedge clk);
      chk("R5 idle sets done", flags[2], 1);
      host_wr(3'd2, 8'h04);
      chk("R5 done held while idle", flags[2], 1);
      tx_en = 1; tx_busy = 1;
      host_wr(3'd2, 8'h04);
      chk("R4 done clears after idle", flags[2], 0);
   endtask

   task automatic t_rx();
      pulse_rx();
      chk("R6 rx set", flags[0], 1);
      host_rd_rx();
      chk("R6 rx cleared by read", flags[0], 0);
      pulse_rx();
      host_wr(3'd3, 8'h01);
      chk("R6 rx cleared by flush", flags[0], 0);
   endtask

   task automatic t_cts();
      cts_async = 0;
      @(negedge clk); @(negedge clk);
      chk("R7 cts not yet", flags[3], 0);
      @(negedge clk);
      chk("R7 cts third edge", flags[3], 1);
      host_wr(3'd2, 8'h08);
      chk("R7 cts W1C", flags[3], 0);
      cts_fc_en = 0; cts_async = 1;
      repeat (4) @(negedge clk);
      chk("R7 cts ignored when disabled", flags[3], 0);
      cts_fc_en = 1;
      repeat (2) @(negedge clk);
      chk("R7 cts no late event", flags[3], 0);
   endtask

   task automatic t_brk();
      brk_det = 1; @(negedge clk); brk_det = 0;
      chk("R8 break set", flags[4], 1);
      chk("R8 break absent variant", flags_nb[4], 0);
      host_wr(3'd2, 8'h10);
      chk("R8 break W1C", flags[4], 0);
   endtask

   task automatic t_prio();
      brk_det = 1; wr_en = 1; addr = 3'd2; wdata = 8'h10;
      @(negedge clk);
      brk_det = 0; wr_en = 0; addr = '0; wdata = '0;
      chk("R9 break set beats clear", flags[4], 1);
      host_wr(3'd2, 8'h10);
      rx_xfer = 1; rd_en = 1; addr = 3'd5;
      @(negedge clk);
      rx_xfer = 0; rd_en = 0; addr = '0;
      chk("R9 rx set beats read", flags[0], 1);
      host_rd_rx();
   endtask

   task automatic t_irq();
      logic [7:0] v;
      pulse_rx();
      chk("R10 irq masked", irq, 0);
      host_wr(3'd1, 8'h01);
      chk("R10 irq enabled", irq, 1);
      peek(3'd1, v);
      chk("R10 enable readback", v, 8'h01);
      host_rd_rx();
      chk("R10 irq drops with flag", irq, 0);
      host_wr(3'd1, 8'h02);
      chk("R10 irq from txe", irq, flags[1]);
      host_wr(3'd1, 8'h00);
   endtask

   task automatic t_ro();
      logic [4:0] snap;
      logic [7:0] v;
      pulse_rx();
      pulse_load();
      snap = flags;
      host_wr(3'd0, 8'h1F);
      chk("R11 status write ignored", flags, snap);
      host_wr(3'd0, 8'h00);
      chk("R11 status write zero ignored", flags, snap);
      host_wr(3'd2, 8'h03);
      chk("R11 clear of bits 0,1 ignored", flags, snap);
      peek(3'd0, v);
      chk("R11 status readback", v, {3'b000, snap});
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      @(negedge clk);
      t_txe();
      t_tc();
      t_idle();
      t_rx();
      t_cts();
      t_brk();
      t_prio();
      t_irq();
      t_ro();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule